// File: doc/BRIEF.md
# SPI Flash Fast-Read Controller

This block is the host side of a serial-flash read path. A single-cycle request carries a 24-bit start address and a byte count. The controller then selects the flash and clocks out the fast-read command byte (0x0B), the address and one dummy byte. After that it keeps the serial clock running and collects data bytes until the requested number has arrived, and then deselects the flash. The flash supplies consecutive bytes on its own and wraps to address zero past its top address. The controller never re-addresses, so a burst may cross that boundary.

The serial clock is made from the system clock. A divider input is latched with each request, and a parameterised floor keeps the serial clock at or below the flash limit of 33 MHz. At the default floor of four system cycles per half period and a 200 MHz system clock, the serial clock runs at 25 MHz. Received bytes leave on a valid/ready stream that holds one byte. A byte is transferred on any cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` is frozen. In that case the controller does not start clocking the next byte: the serial clock is parked low at the byte boundary, so no data is ever dropped or overwritten. `rd_valid` may drop on any cycle after the transfer.

Control is plain. `start` is honoured only while `busy` is low. `busy` covers the whole request, and `done` pulses once as the flash is deselected.

Top module: `spi_fastread_ctrl`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `rd_valid` are 0.
- R2: Once `spi_cs_n` falls, the first 32 bits on `spi_mosi` are the opcode 0x0B and then the 24 address bits, each sent most significant bit first. `spi_mosi` never changes while `spi_sclk` is high.
- R3: After the address come 8 dummy clocks. Data bits are then sampled on the rising edges of `spi_sclk`, so one transfer with length N has exactly 40 + 8·N rising edges.
- R4: Each byte on `rd_data` is the byte the flash shifted in, most significant bit first, delivered in arrival order. This includes bursts that cross the flash's wrap to address zero.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_data` is held. No further serial clock edge occurs after the held byte completes until the slot is emptied, and no byte is lost or overwritten.
- R6: A request with length N gives exactly one chip-select period and exactly N stream bytes. A request with length 0 is ignored: `busy` stays low and `spi_cs_n` stays high.
- R7: `spi_sclk` idles low (mode 0) and is low whenever `spi_cs_n` is high.
- R8: Each high half of `spi_sclk` lasts exactly H system cycles, and each low half lasts at least H. H = max(`clk_div`+1, MIN_HALF), taken when the request is accepted.
- R9: `busy` rises in the cycle after an accepted `start` and falls as `spi_cs_n` rises. `done` is a one-cycle pulse in that same cycle, once per transfer.
- R10: Between two transfers `spi_cs_n` stays high for at least 2·H system cycles. A request made within that window is held and started afterwards.
- R11: `start` while `busy` is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, honoured while not busy |
| start_addr | input | 24 | Flash byte address of the first byte |
| start_len | input | LEN_W (16) | Number of bytes to read; 0 is ignored |
| clk_div | input | DIV_W (8) | Half period of the serial clock in system cycles, minus one |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when the flash is deselected |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
A wrong header counter or a wrong shift register shows at once as a misread opcode or address in the flash model. It also shows as a rising-edge count that differs from 40 + 8·N at the end of the same transfer. A wrong byte counter or bit counter appears as missing or extra stream bytes, or as a chip-select period of the wrong length, and it is caught when `done` arrives. A bad stall condition or a bad output register shows within one byte time under back-pressure: the serial clock moves while a byte is held, or a held byte changes. A wrong divider or gap counter shows at the first clock edge or at the next chip-select fall, as a measured half period or gap below its bound.

// File: rtl/spifr_pkg.sv
package spifr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;

  localparam logic [7:0] FAST_READ_OP = 8'h0B;
  localparam int         OP_BITS      = 8;
  localparam int         DUMMY_BITS   = 8;
endpackage

// File: rtl/spifr_clkgen.sv
module spifr_clkgen #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] half,
  output logic          half_end
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == half - CW'(1)) cnt <= '0;
      else                      cnt <= cnt + CW'(1);
    end
  end

  assign half_end = en && !clr && (cnt == half - CW'(1));

  // R8: the phase counter never runs past the latched half period
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < half));
endmodule

// File: rtl/spifr_txshift.sv
module spifr_txshift #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         bit_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_o = sr[W-1];
endmodule

// File: rtl/spifr_rxshift.sv
module spifr_rxshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (sample) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/spi_fastread_ctrl.sv
module spi_fastread_ctrl
  import spifr_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4,
  parameter int ADDR_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic [DIV_W-1:0] clk_div,
  output logic             busy,
  output logic             done,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready
);
  localparam int CW       = DIV_W + 1;
  localparam int GW       = CW + 1;
  localparam int HDR_BITS = OP_BITS + ADDR_W + DUMMY_BITS;
  localparam int HDR_W    = $clog2(HDR_BITS);

  function automatic logic [CW-1:0] eff_half(input logic [DIV_W-1:0] d);
    logic [CW-1:0] h;
    h = CW'(d) + CW'(1);
    if (h < CW'(MIN_HALF)) h = CW'(MIN_HALF);
    return h;
  endfunction

  seq_state_t       st;
  logic [CW-1:0]    half_q;
  logic [LEN_W-1:0] bytes_left;
  logic [HDR_W-1:0] hdr_cnt;
  logic [2:0]       bitidx;
  logic             in_data;
  logic             phase_hi;
  logic             cs_q;
  logic             done_q;
  logic [GW-1:0]    gap_cnt;
  logic [7:0]       out_data;
  logic             out_valid;
  logic [7:0]       rx_q;

  logic accept, stall, run, half_end, rise, fall, byte_fall, hdr_fall, last_fall;

  assign accept    = start && (st == ST_IDLE) && (start_len != '0);
  assign stall     = in_data && (bitidx == 3'd0) && !phase_hi && out_valid;
  assign run       = (st == ST_XFER) && !stall;
  assign rise      = half_end && !phase_hi;
  assign fall      = half_end && phase_hi;
  assign hdr_fall  = fall && !in_data;
  assign byte_fall = fall && in_data && (bitidx == 3'd7);
  assign last_fall = byte_fall && (bytes_left == LEN_W'(1));

  spifr_clkgen #(.CW(CW)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st == ST_GAP),
    .en       (run),
    .half     (half_q),
    .half_end (half_end)
  );

  spifr_txshift #(.W(HDR_BITS)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   ({FAST_READ_OP, start_addr, {DUMMY_BITS{1'b0}}}),
    .shift (hdr_fall),
    .bit_o (spi_mosi)
  );

  spifr_rxshift #(.W(8)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (rise && in_data),
    .din    (spi_miso),
    .q      (rx_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      half_q     <= CW'(MIN_HALF);
      bytes_left <= '0;
      hdr_cnt    <= '0;
      bitidx     <= '0;
      in_data    <= 1'b0;
      phase_hi   <= 1'b0;
      cs_q       <= 1'b1;
      done_q     <= 1'b0;
      gap_cnt    <= '0;
    end else begin
      done_q <= 1'b0;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - GW'(1);
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st         <= ST_GAP;
            half_q     <= eff_half(clk_div);
            bytes_left <= start_len;
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) begin
            st       <= ST_XFER;
            cs_q     <= 1'b0;
            phase_hi <= 1'b0;
            hdr_cnt  <= '0;
            in_data  <= 1'b0;
            bitidx   <= '0;
          end
        end
        ST_XFER: begin
          if (rise) phase_hi <= 1'b1;
          if (fall) begin
            phase_hi <= 1'b0;
            if (!in_data) begin
              if (hdr_cnt == HDR_W'(HDR_BITS - 1)) in_data <= 1'b1;
              else                                 hdr_cnt <= hdr_cnt + HDR_W'(1);
            end else begin
              bitidx <= bitidx + 3'd1;
              if (bitidx == 3'd7) begin
                if (bytes_left == LEN_W'(1)) begin
                  st      <= ST_IDLE;
                  cs_q    <= 1'b1;
                  done_q  <= 1'b1;
                  gap_cnt <= {half_q, 1'b0};
                end else begin
                  bytes_left <= bytes_left - LEN_W'(1);
                end
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (byte_fall) begin
      out_valid <= 1'b1;
      out_data  <= rx_q;
    end else if (out_valid && rd_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign spi_sclk = phase_hi;
  assign spi_cs_n = cs_q;
  assign rd_data  = out_data;
  assign rd_valid = out_valid;

  // R7: no clock activity while the flash is deselected
  a_r7_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R9: an idle controller never selects the flash
  a_r9_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  // R9: done marks the release of chip-select
  a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !$past(spi_cs_n)));
  // R5: a completed byte never lands on an occupied slot
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fall |-> !out_valid);
  // R5: held data stays put under back-pressure
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R2: data out only moves while the serial clock is low
  a_r2_mosi_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  // R6: a zero-length request leaves the controller idle
  a_r6_len0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (start_len == '0)) |=> !busy);
endmodule

// File: tb/test_spi_fastread_ctrl.sv
module test_spi_fastread_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] s_addr = '0;
  logic [15:0] s_len = '0;
  logic [7:0]  s_div = '0;
  logic        busy, done, spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  spi_fastread_ctrl i_spi_fastread_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(s_addr),
    .start_len(s_len), .clk_div(s_div), .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  // system cycle counter
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // flash model: 64 KiB array whose address wraps past 0xFFFF
  int          f_rises = 0;
  int          frames = 0;
  logic [7:0]  f_op = '0;
  logic [23:0] f_addr = '0;
  always @(negedge spi_cs_n) begin
    frames++;
    f_rises = 0;
    f_op = '0;
    f_addr = '0;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (f_rises < 8)       f_op   = {f_op[6:0], spi_mosi};
    else if (f_rises < 32) f_addr = {f_addr[22:0], spi_mosi};
    f_rises++;
  end
  always @(negedge spi_sclk) if (!spi_cs_n && f_rises >= 40) begin
    logic [15:0] a;
    logic [7:0]  b;
    int k;
    a = f_addr[15:0] + 16'((f_rises - 40) / 8);
    k = (f_rises - 40) % 8;
    b = memf(a);
    spi_miso = b[7-k];
  end

  // serial clock timing and chip-select gap measurement
  longint last_edge = 0, last_rise_cs = 0;
  longint hi_min = 0, hi_max = 0, lo_min = 0, gap_min = 0;
  bit     have_rise = 0;
  always @(negedge spi_cs_n) begin
    last_edge = cyc;
    if (have_rise && (cyc - last_rise_cs) < gap_min) gap_min = cyc - last_rise_cs;
  end
  always @(posedge spi_cs_n) begin
    last_rise_cs = cyc;
    have_rise = 1;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (cyc - last_edge < lo_min) lo_min = cyc - last_edge;
    last_edge = cyc;
  end
  always @(negedge spi_sclk) begin
    if (cyc - last_edge < hi_min) hi_min = cyc - last_edge;
    if (cyc - last_edge > hi_max) hi_max = cyc - last_edge;
    last_edge = cyc;
  end

  // consumer, done and mosi monitors, sampled between edges
  int         rmode = 0;
  int         rtick = 0;
  int         ngot = 0;
  logic [7:0] got [0:63];
  int         hold_err = 0, hold_seen = 0, done_cnt = 0, done_bad = 0, mosi_bad = 0;
  bit         hold_prev = 0;
  logic [7:0] hold_data = '0;
  logic       prev_cs = 1'b1, prev_mosi = 1'b0;
  always @(negedge clk) begin
    rtick++;
    case (rmode)
      0:       rd_ready = 1'b1;
      1:       rd_ready = (rtick % 23 == 0);
      default: rd_ready = 1'b0;
    endcase
    if (hold_prev && !(rd_valid && rd_data == hold_data)) hold_err++;
    hold_prev = rd_valid && !rd_ready;
    hold_data = rd_data;
    if (hold_prev) hold_seen++;
    if (rd_valid && rd_ready && ngot < 64) begin
      got[ngot] = rd_data;
      ngot++;
    end
    if (done) begin
      done_cnt++;
      if (!(spi_cs_n && !prev_cs)) done_bad++;
    end
    if (!spi_cs_n && spi_sclk && spi_mosi != prev_mosi) mosi_bad++;
    prev_cs = spi_cs_n;
    prev_mosi = spi_mosi;
  end

  task automatic clear_stats();
    hi_min = 1000000; hi_max = 0; lo_min = 1000000; gap_min = 1000000;
    ngot = 0; hold_err = 0; hold_seen = 0;
  endtask

  task automatic pulse_start(input logic [23:0] a, input int n, input logic [7:0] dv);
    @(negedge clk);
    start = 1'b1; s_addr = a; s_len = 16'(n); s_div = dv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_bytes(input logic [23:0] a, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n && i < 64; i++)
      if (got[i] !== memf(a[15:0] + 16'(i))) begin
        if (bad == 0) chk(0, req, $sformatf("byte %0d", i), got[i], memf(a[15:0] + 16'(i)));
        bad++;
      end
    if (bad == 0) chk(1, req, "bytes", 0, 0);
  endtask

  task automatic run_xfer(input logic [23:0] a, input int n, input logic [7:0] dv,
                          input int mode);
    int d0, f0, t;
    rmode = mode;
    clear_stats();
    d0 = done_cnt; f0 = frames;
    pulse_start(a, n, dv);
    chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
    while (done_cnt == d0) @(negedge clk);
    chk(busy === 1'b0 && spi_cs_n === 1'b1, "R9", "idle at done", busy, 0);
    t = 0;
    while (ngot < n && t < 4000) begin @(negedge clk); t++; end
    chk(frames - f0 == 1, "R6", "one select period", frames - f0, 1);
    chk(f_op == 8'h0B, "R2", "opcode", f_op, 8'h0B);
    chk(f_addr == a, "R2", "address", f_addr, a);
    chk(f_rises == 40 + 8 * n, "R3", "rising edges", f_rises, 40 + 8 * n);
    chk(ngot == n, "R6", "byte count", ngot, n);
    check_bytes(a, n, "R4");
    chk(done_cnt - d0 == 1 && done_bad == 0, "R9", "done pulses", done_cnt - d0, 1);
    chk(mosi_bad == 0, "R2", "mosi moved while sclk high", mosi_bad, 0);
  endtask

  task automatic t_reset();
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "cs/sclk in reset", spi_cs_n, 1);
    chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R1", "busy/done/valid", busy, 0);
    chk(spi_sclk === 1'b0, "R7", "sclk idles low", spi_sclk, 0);
  endtask

  task automatic t_basic();
    run_xfer(24'h001230, 4, 8'd0, 0);
    chk(hi_min == 4 && hi_max == 4, "R8", "high half at clamp", hi_max, 4);
    chk(lo_min == 4, "R8", "low half at clamp", lo_min, 4);
  endtask

  task automatic t_div();
    run_xfer(24'h00A5A0, 3, 8'd9, 0);
    chk(hi_min == 10 && hi_max == 10, "R8", "high half div 9", hi_max, 10);
    chk(lo_min == 10, "R8", "low half div 9", lo_min, 10);
  endtask

  task automatic t_wrap();
    run_xfer(24'h00FFFE, 4, 8'd2, 0);
    chk(hi_max == 4, "R8", "div 2 clamped", hi_max, 4);
  endtask

  task automatic t_backpressure();
    run_xfer(24'h000100, 6, 8'd0, 1);
    chk(hold_seen > 0 && hold_err == 0, "R5", "held data stable", hold_err, 0);
  endtask

  task automatic t_stall();
    int d0, r0, t;
    rmode = 2;
    clear_stats();
    d0 = done_cnt;
    pulse_start(24'h000040, 3, 8'd0);
    t = 0;
    while (!rd_valid && t < 4000) begin @(negedge clk); t++; end
    r0 = f_rises;
    chk(r0 == 48, "R5", "edges at first byte", r0, 48);
    repeat (200) @(negedge clk);
    chk(f_rises == r0 && spi_sclk === 1'b0, "R5", "clock parked", f_rises, r0);
    chk(rd_valid === 1'b1 && rd_data == memf(16'h0040), "R5", "byte held", rd_data, memf(16'h0040));
    rmode = 0;
    while (done_cnt == d0) @(negedge clk);
    t = 0;
    while (ngot < 3 && t < 4000) begin @(negedge clk); t++; end
    chk(ngot == 3, "R5", "no byte lost", ngot, 3);
    check_bytes(24'h000040, 3, "R5");
  endtask

  task automatic t_len0();
    int f0, bad = 0;
    f0 = frames;
    pulse_start(24'h000010, 0, 8'd0);
    repeat (40) begin
      @(negedge clk);
      if (busy !== 1'b0 || spi_cs_n !== 1'b1) bad++;
    end
    chk(bad == 0 && frames == f0, "R6", "zero length ignored", bad, 0);
  endtask

  task automatic t_busy_start();
    int d0, f0, t;
    rmode = 0;
    clear_stats();
    d0 = done_cnt; f0 = frames;
    pulse_start(24'h000800, 2, 8'd0);
    repeat (20) @(negedge clk);
    pulse_start(24'h00BEEF, 1, 8'd5);
    while (done_cnt == d0) @(negedge clk);
    t = 0;
    while (ngot < 2 && t < 4000) begin @(negedge clk); t++; end
    chk(frames - f0 == 1 && f_addr == 24'h000800, "R11", "second start ignored", f_addr, 24'h000800);
    chk(f_rises == 56 && ngot == 2, "R11", "length kept", f_rises, 56);
    check_bytes(24'h000800, 2, "R11");
  endtask

  task automatic t_gap();
    longint g;
    run_xfer(24'h000200, 1, 8'd1, 0);
    have_rise = 1;
    gap_min = 1000000;
    pulse_start(24'h000300, 1, 8'd1);
    while (spi_cs_n) @(negedge clk);
    g = gap_min;
    chk(g >= 8, "R10", "deselect gap", g, 8);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(f_addr == 24'h000300 && f_rises == 48, "R10", "held request ran", f_addr, 24'h000300);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_div();
    t_wrap();
    t_backpressure();
    t_stall();
    t_len0();
    t_busy_start();
    t_gap();
    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule